// File: doc/BRIEF.md
# Windowed Register File

This block is a register file for a processor whose calling convention rotates register windows instead of saving registers on every call. Software names 32 registers with a 5-bit number. Eight of them are globals that every procedure shares. The remaining 24 form the current window, which has three groups of eight: incoming arguments, private locals and outgoing arguments. The physical array is much larger than the visible set, so a call or a return only moves a window pointer and copies nothing to memory.

Each window's outgoing group is the same storage as the incoming group of the window one step lower. When a call moves the pointer down by one, the caller's outgoing arguments become the callee's incoming arguments. A return moves the pointer back up, so values the callee left in its incoming group appear in the caller's outgoing group.

A small counter tracks how many calls are resident in the array. A call that would reuse a window still in use raises an overflow flag. A return with no resident call raises an underflow flag. The pointer stays where it is in both cases, and a trap handler outside this block deals with the flag. The block has two combinational read ports and one write port. A read sees a write to the same register made in the same cycle.

Top module: `wrf_top`

## Requirements
- R1: After reset the window pointer is at its home position with no call resident. With no strobe asserted, both `overflow` and `underflow` are 0.
- R2: Register numbers 1 to 7 (bits [4:3] = 00) address global storage. They read the same values from every window.
- R3: Register 0 always reads as 0 on both ports, even in the cycle it is written. A write to register 0 has no effect.
- R4: Register numbers 8 to 15 (bits [4:3] = 01) are outgoing and 24 to 31 (bits [4:3] = 11) are incoming. After an accepted call, incoming register 24+i reads the value the caller had in outgoing register 8+i.
- R5: Register numbers 16 to 23 (bits [4:3] = 10) are locals private to each window. The callee's locals are separate storage from the caller's, and the caller's locals are unchanged after a return.
- R6: After an accepted return, the caller's outgoing register 8+i reads the value the callee last had in incoming register 24+i. Each return restores the locals of the previous window in order.
- R7: With NWIN windows (default 8), at most NWIN-2 calls can be resident. A call (`call_req`=1, `ret_req`=0) when NWIN-2 calls are resident sets `overflow` to 1 in that same cycle and leaves the pointer unmoved.
- R8: A return (`ret_req`=1, `call_req`=0) when no call is resident sets `underflow` to 1 in that same cycle and leaves the pointer unmoved.
- R9: When `we`=1, a read port whose address equals `wa` (other than 0) returns `wd` in the same cycle. From the next cycle on, it returns the stored value.
- R10: A cycle with `call_req` and `ret_req` both 1 moves nothing and raises neither flag.
- R11: A write made in the same cycle as an accepted call goes to the caller's window, using the pointer value from before the call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ra_addr | input | 5 | Register number for read port A |
| ra_data | output | DW | Read port A data, combinational |
| rb_addr | input | 5 | Register number for read port B |
| rb_data | output | DW | Read port B data, combinational |
| we | input | 1 | Write enable |
| wa | input | 5 | Register number to write |
| wd | input | DW | Write data |
| call_req | input | 1 | Advance to a new window (procedure call) |
| ret_req | input | 1 | Go back to the previous window (procedure return) |
| overflow | output | 1 | The call in this cycle was refused because every window is in use |
| underflow | output | 1 | The return in this cycle was refused because no call is resident |

## Verification
The assertions take for granted that every input is at a known level from the first clock edge after reset. They also assume that the strobes and the write port are sampled only at rising edges, so the pointer relations they check hold cycle by cycle. The stimulus drives every input to a defined value from time zero and changes inputs only on falling edges. It reads only registers it has already written in the window being read, so no check depends on storage contents that were never initialised. The overflow sequence fills every allowed window and then unwinds it completely, so each pointer step is paired with a locals check.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned GRP_REGS = 8;
  localparam int unsigned LADDR_W  = 5;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } grp_e;
endpackage

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned WPW  = $clog2(NWIN),
  parameter int unsigned OW   = $clog2(NWIN - 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_req,
  input  logic           ret_req,
  output logic [WPW-1:0] cwp,
  output logic [OW-1:0]  occ,
  output logic           overflow,
  output logic           underflow
);
  localparam int unsigned MAX_OCC = NWIN - 2;

  logic [WPW-1:0] cwp_q, cwp_d;
  logic [OW-1:0]  occ_q, occ_d;
  logic           full, empty, call_only, ret_only, do_call, do_ret, state_en;

  // decode strobes; both at once is a no-op
  always_comb begin
    call_only = call_req & ~ret_req;
    ret_only  = ret_req & ~call_req;
    full      = (occ_q == OW'(MAX_OCC));
    empty     = (occ_q == '0);
    do_call   = call_only & ~full;
    do_ret    = ret_only & ~empty;
    overflow  = call_only & full;
    underflow = ret_only & empty;
    state_en  = do_call | do_ret;
  end

  // next-state: call steps the pointer down, return steps it up
  always_comb begin
    cwp_d = cwp_q;
    occ_d = occ_q;
    if (do_call) begin
      cwp_d = (cwp_q == '0) ? WPW'(NWIN - 1) : cwp_q - 1'b1;
      occ_d = occ_q + 1'b1;
    end else if (do_ret) begin
      cwp_d = (cwp_q == WPW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
      occ_d = occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      occ_q <= '0;
    end else if (state_en) begin
      cwp_q <= cwp_d;
      occ_q <= occ_d;
    end
  end

  assign cwp = cwp_q;
  assign occ = occ_q;
endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned WPW  = $clog2(NWIN),
  parameter int unsigned PW   = $clog2(GRP_REGS + NWIN * 2 * GRP_REGS)
) (
  input  logic [LADDR_W-1:0] laddr,
  input  logic [WPW-1:0]     cwp,
  output logic [PW-1:0]      paddr,
  output logic               is_zero
);
  // physical layout: globals first, then per window {locals, ins}
  localparam int unsigned WIN_SPAN = 2 * GRP_REGS;

  grp_e           grp;
  logic [2:0]     off;
  logic [WPW-1:0] wprev;
  int unsigned    base_cur, base_prev;

  always_comb begin
    grp       = grp_e'(laddr[4:3]);
    off       = laddr[2:0];
    wprev     = (cwp == '0) ? WPW'(NWIN - 1) : cwp - 1'b1;
    base_cur  = GRP_REGS + int'(cwp) * WIN_SPAN;
    base_prev = GRP_REGS + int'(wprev) * WIN_SPAN;
    is_zero   = (laddr == '0);
    unique case (grp)
      GRP_GLOBAL: paddr = PW'(int'(off));
      GRP_OUT:    paddr = PW'(base_prev + GRP_REGS + int'(off));
      GRP_LOCAL:  paddr = PW'(base_cur + int'(off));
      default:    paddr = PW'(base_cur + GRP_REGS + int'(off));
    endcase
  end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned PHYS = 136,
  parameter int unsigned PW   = $clog2(PHYS),
  parameter int unsigned DW   = 32,
  parameter int unsigned NRD  = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [PW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][PW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] mem [PHYS];
  logic          wr_en;

  // physical slot 0 backs the hard zero register and is never written
  assign wr_en = we & (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [4:0]    rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [4:0]    wa,
  input  logic [DW-1:0] wd,
  input  logic          call_req,
  input  logic          ret_req,
  output logic          overflow,
  output logic          underflow
);
  localparam int unsigned NRD  = 2;
  localparam int unsigned NMAP = NRD + 1;
  localparam int unsigned PHYS = GRP_REGS + NWIN * 2 * GRP_REGS;
  localparam int unsigned PW   = $clog2(PHYS);
  localparam int unsigned WPW  = $clog2(NWIN);
  localparam int unsigned OW   = $clog2(NWIN - 1);

  // reset: asserted at once, released after two clock edges
  logic rst_s0, rst_s1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_core_n = rst_s1;

  logic [WPW-1:0] cwp;
  logic [OW-1:0]  occ;

  wrf_window_ctl #(.NWIN(NWIN), .WPW(WPW), .OW(OW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .cwp       (cwp),
    .occ       (occ),
    .overflow  (overflow),
    .underflow (underflow)
  );

  // map index NRD is the write port, 0..NRD-1 the read ports
  logic [NMAP-1:0][4:0]    laddr;
  logic [NMAP-1:0][PW-1:0] paddr;
  logic [NMAP-1:0]         is_zero;

  assign laddr[0]   = ra_addr;
  assign laddr[1]   = rb_addr;
  assign laddr[NRD] = wa;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_map (
      .laddr   (laddr[m]),
      .cwp     (cwp),
      .paddr   (paddr[m]),
      .is_zero (is_zero[m])
    );
  end

  logic [NRD-1:0][PW-1:0] rd_paddr;
  logic [NRD-1:0][DW-1:0] rd_raw;
  logic [NRD-1:0][DW-1:0] rd_out;

  for (genvar p = 0; p < NRD; p++) begin : g_rdaddr
    assign rd_paddr[p] = paddr[p];
  end

  wrf_storage #(.PHYS(PHYS), .PW(PW), .DW(DW), .NRD(NRD)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (paddr[NRD]),
    .wdata (wd),
    .raddr (rd_paddr),
    .rdata (rd_raw)
  );

  // hard zero first, then write-first forwarding, then stored data
  for (genvar p = 0; p < NRD; p++) begin : g_byp
    always_comb begin
      if (is_zero[p])
        rd_out[p] = '0;
      else if (we && !is_zero[NRD] && (paddr[NRD] == paddr[p]))
        rd_out[p] = wd;
      else
        rd_out[p] = rd_raw[p];
    end
  end

  assign ra_data = rd_out[0];
  assign rb_data = rd_out[1];
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned WPW  = $clog2(NWIN),
  parameter int unsigned OW   = $clog2(NWIN - 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [4:0]     ra_addr,
  input logic [DW-1:0]  ra_data,
  input logic [4:0]     rb_addr,
  input logic [DW-1:0]  rb_data,
  input logic           we,
  input logic [4:0]     wa,
  input logic [DW-1:0]  wd,
  input logic           call_req,
  input logic           ret_req,
  input logic           overflow,
  input logic           underflow,
  input logic [WPW-1:0] cwp,
  input logic [OW-1:0]  occ
);
  // R1: the two flags never fire together
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));

  // R3: register 0 reads zero on both ports
  a_r3_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == 5'd0) |-> (ra_data == '0));
  a_r3_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_addr == 5'd0) |-> (rb_data == '0));

  // R9: same-cycle write reaches the read port
  a_r9_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != 5'd0 && wa == ra_addr) |-> (ra_data == wd));

  // R4: an accepted call steps the pointer down by one
  a_r4_call_step: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !ret_req && !overflow) |=>
      (cwp == (($past(cwp) == '0) ? WPW'(NWIN - 1) : $past(cwp) - 1'b1)));

  // R6: an accepted return steps the pointer up by one
  a_r6_ret_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && !underflow) |=>
      (cwp == (($past(cwp) == WPW'(NWIN - 1)) ? '0 : $past(cwp) + 1'b1)));

  // R7: overflow only at full occupancy, and the pointer holds
  a_r7_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (call_req && occ == OW'(NWIN - 2)));
  a_r7_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> $stable(cwp));

  // R8: underflow only with nothing resident, and the pointer holds
  a_r8_underflow_empty: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (ret_req && occ == '0));
  a_r8_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> $stable(cwp));

  // R10: both strobes at once change nothing
  a_r10_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && ret_req) |=> ($stable(cwp) && $stable(occ)));
  a_r10_both_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && ret_req) |-> (!overflow && !underflow));

  logic unused_ok;
  assign unused_ok = ^{rb_addr, rb_data};
endmodule

bind wrf_top wrf_checker #(.NWIN(NWIN), .DW(DW), .WPW(WPW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ra_addr   (ra_addr),
  .ra_data   (ra_data),
  .rb_addr   (rb_addr),
  .rb_data   (rb_data),
  .we        (we),
  .wa        (wa),
  .wd        (wd),
  .call_req  (call_req),
  .ret_req   (ret_req),
  .overflow  (overflow),
  .underflow (underflow),
  .cwp       (cwp),
  .occ       (occ)
);

// File: tb/sim_wrf_top.sv
module sim_wrf_top;
  localparam int NWIN = 8;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    ra_addr = '0, rb_addr = '0, wa = '0;
  logic [DW-1:0] wd = '0;
  logic          we = 1'b0, call_req = 1'b0, ret_req = 1'b0;
  logic [DW-1:0] ra_data, rb_data;
  logic          overflow, underflow;

  always #5 clk = ~clk;

  wrf_top #(.NWIN(NWIN), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data),
    .we(we), .wa(wa), .wd(wd),
    .call_req(call_req), .ret_req(ret_req),
    .overflow(overflow), .underflow(underflow)
  );

  // 0: ra_data, 1: rb_data, 2: overflow, 3: underflow
  typedef struct {
    string         req;
    int            sel;
    logic [DW-1:0] val;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  task automatic push(input string req, input int sel, input logic [DW-1:0] val);
    exp_t e;
    e.req = req; e.sel = sel; e.val = val;
    q.push_back(e);
  endtask

  task automatic drv(input logic w, input logic [4:0] a, input logic [DW-1:0] d,
                     input logic [4:0] x, input logic [4:0] y,
                     input logic c, input logic r);
    @(negedge clk);
    we = w; wa = a; wd = d; ra_addr = x; rb_addr = y; call_req = c; ret_req = r;
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    drv(1'b1, a, d, 5'd0, 5'd0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [4:0] x, input logic [4:0] y);
    drv(1'b0, 5'd0, '0, x, y, 1'b0, 1'b0);
  endtask

  // monitor: compares queued expectations in the middle of the low phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [DW-1:0] act;
        e = q.pop_front();
        case (e.sel)
          0:       act = ra_data;
          1:       act = rb_data;
          2:       act = DW'(overflow);
          default: act = DW'(underflow);
        endcase
        n_tests++;
        if (act !== e.val) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, act, e.val);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: idle after reset, no flags
    rd(5'd0, 5'd0);
    push("R1", 2, 0); push("R1", 3, 0);

    // fill the home window and the globals
    for (int i = 1; i < 8; i++) wr(5'(i), DW'(32'h10 + i));
    wr(5'd0, 32'hDEAD);
    for (int i = 0; i < 8; i++) begin
      wr(5'(8 + i),  DW'(32'h100 + i));
      wr(5'(16 + i), DW'(32'h200 + i));
      wr(5'(24 + i), DW'(32'h300 + i));
    end

    // R8 / R1: return right after reset is refused
    drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b0, 1'b1);
    push("R8", 3, 1); push("R1", 2, 0);
    rd(5'd16, 5'd31);
    push("R8", 0, 32'h200); push("R8", 1, 32'h307);

    // R3: zero register
    rd(5'd0, 5'd0);
    push("R3", 0, 0); push("R3", 1, 0);
    drv(1'b1, 5'd0, 32'hBEEF, 5'd0, 5'd0, 1'b0, 1'b0);
    push("R3", 0, 0); push("R3", 1, 0);
    rd(5'd0, 5'd1);
    push("R3", 0, 0); push("R2", 1, 32'h11);

    // R9: write-first forwarding on each port
    drv(1'b1, 5'd9, 32'hAAAA, 5'd9, 5'd10, 1'b0, 1'b0);
    push("R9", 0, 32'hAAAA); push("R9", 1, 32'h102);
    drv(1'b1, 5'd20, 32'h5555, 5'd3, 5'd20, 1'b0, 1'b0);
    push("R2", 0, 32'h13); push("R9", 1, 32'h5555);
    rd(5'd9, 5'd20);
    push("R9", 0, 32'hAAAA); push("R9", 1, 32'h5555);

    // R4: call maps caller outs onto callee ins
    drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b1, 1'b0);
    push("R4", 2, 0); push("R4", 3, 0);
    rd(5'd24, 5'd25);
    push("R4", 0, 32'h100); push("R4", 1, 32'hAAAA);
    rd(5'd31, 5'd7);
    push("R4", 0, 32'h107); push("R2", 1, 32'h17);
    rd(5'd1, 5'd0);
    push("R2", 0, 32'h11); push("R3", 1, 0);

    wr(5'd16, 32'h1200);
    wr(5'd8,  32'h1100);
    wr(5'd24, 32'h1300);
    rd(5'd16, 5'd8);
    push("R5", 0, 32'h1200); push("R5", 1, 32'h1100);

    // R6: return brings callee ins back as caller outs
    drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b0, 1'b1);
    push("R6", 2, 0); push("R6", 3, 0);
    rd(5'd8, 5'd16);
    push("R6", 0, 32'h1300); push("R5", 1, 32'h200);
    rd(5'd20, 5'd15);
    push("R5", 0, 32'h5555); push("R6", 1, 32'h107);

    // R7: fill all allowed windows, then one call too many
    for (int k = 1; k <= NWIN - 2; k++) begin
      drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b1, 1'b0);
      push("R7", 2, 0);
      wr(5'd16, DW'(32'h500 + k));
    end
    drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b1, 1'b0);
    push("R7", 2, 1); push("R7", 3, 0);
    rd(5'd16, 5'd0);
    push("R7", 0, DW'(32'h500 + NWIN - 2));

    // R6: unwind, each return restores the previous locals
    for (int k = NWIN - 3; k >= 0; k--) begin
      drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b0, 1'b1);
      push("R8", 3, 0);
      rd(5'd16, 5'd0);
      push("R6", 0, (k == 0) ? DW'(32'h200) : DW'(32'h500 + k));
    end
    drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b0, 1'b1);
    push("R8", 3, 1);
    rd(5'd16, 5'd0);
    push("R8", 0, 32'h200);

    // R10: both strobes together
    drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b1, 1'b1);
    push("R10", 2, 0); push("R10", 3, 0);
    rd(5'd16, 5'd24);
    push("R10", 0, 32'h200); push("R10", 1, 32'h300);

    // R11: write alongside a call lands in the caller window
    drv(1'b1, 5'd16, 32'h777, 5'd0, 5'd0, 1'b1, 1'b0);
    push("R11", 2, 0);
    rd(5'd16, 5'd24);
    push("R11", 0, 32'h501); push("R11", 1, 32'h1300);
    drv(1'b0, 5'd0, '0, 5'd0, 5'd0, 1'b0, 1'b1);
    rd(5'd16, 5'd0);
    push("R11", 0, 32'h777);

    rd(5'd0, 5'd0);
    @(negedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule